// File: doc/BRIEF.md
# SD Command Issue Gate and Slot Interrupt

This block sits beside an SD host controller's register file. Each time software writes the command register, the gate decides whether the command can go to the card now. It looks at the state of the card clock, the slot power and the data line. It returns a single-cycle pulse: either permit or refuse. The command sequencer downstream acts only on the permit pulse.

The same block also forms the slot's one interrupt line. It combines the normal interrupt status with its signal enables and the error interrupt status with its signal enables. It also combines the card-insert and card-remove status bits with their wake-up enables.

The power check is conditional. Slot power is required only when one of two power-signal control bits in the second control register is set. While both bits are clear, the slot counts as powered whatever the power bit says.

Top module: `sd_cmd_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cmd_issue`, `cmd_reject` and `irq` are all low.
- R2: A command written while `clk_on` is low is refused.
- R3: A command written while `pwr_on` is low is refused if `ctl2` bit 12 or `ctl2` bit 3 is set. If both bits are clear, `pwr_on` has no effect on the decision.
- R4: A command uses the data line when `cmd_data_present` is 1, or when `cmd_rsp_type` equals 3 (response with busy). The other response codes are 0 (none), 1 (136-bit) and 2 (48-bit).
- R5: A data-line command is refused while `dat_inhibit` or `stopped` is high, unless its `cmd_type` equals 3 (abort).
- R6: A command that does not use the data line is not affected by `dat_inhibit` or `stopped`.
- R7: For each cycle in which `cmd_wr` is high, exactly one of `cmd_issue` and `cmd_reject` is high in the next cycle. Both are low in the cycle after a cycle with `cmd_wr` low. A command meeting none of the refusal conditions is issued.
- R8: `irq` is high one cycle after any normal status bit is set together with its signal enable, or any error status bit is set together with its signal enable.
- R9: `irq` is also high one cycle after `norm_sts` bit INS_POS (card inserted) is set with `wake_ins_en` high, or `norm_sts` bit REM_POS (card removed) is set with `wake_rem_en` high.
- R10: When none of the conditions in R8 and R9 holds, `irq` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_on | input | 1 | Card clock enabled and stable |
| pwr_on | input | 1 | Slot power bit |
| ctl2 | input | CTL_W | Second control register |
| dat_inhibit | input | 1 | Data line busy status |
| stopped | input | 1 | Transfer stopped at block gap |
| cmd_wr | input | 1 | Command register write completes this cycle |
| cmd_data_present | input | 1 | Command data-present field |
| cmd_rsp_type | input | 2 | Command response type field |
| cmd_type | input | 2 | Command type field (3 = abort) |
| norm_sts | input | NORM_W | Normal interrupt status |
| norm_sig_en | input | NORM_W | Normal interrupt signal enables |
| err_sts | input | ERR_W | Error interrupt status |
| err_sig_en | input | ERR_W | Error interrupt signal enables |
| wake_ins_en | input | 1 | Wake on card insert enable |
| wake_rem_en | input | 1 | Wake on card remove enable |
| cmd_issue | output | 1 | One-cycle permit pulse |
| cmd_reject | output | 1 | One-cycle refuse pulse |
| irq | output | 1 | Slot interrupt line |

## Verification
The bench builds the gate with a 16-bit normal status, a 10-bit error status that differs from the default, and the insert and remove positions at 6 and 7. The narrower error vector lets random enables and status line up often, so single error bits can be seen raising the line. Sparse random normal status isolates the insert and remove bits. This shows the wake enables raising the interrupt with every signal enable clear. Directed cases cover each power-bit combination and an abort sent while the data line is busy.

// File: rtl/sd_cmd_gate.sv
module sd_cmd_gate #(
  parameter int NORM_W  = 16,
  parameter int ERR_W   = 16,
  parameter int CTL_W   = 32,
  parameter int INS_POS = 6,
  parameter int REM_POS = 7,
  parameter int OPC_POS = 12,
  parameter int IPC_POS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_on,
  input  logic              pwr_on,
  input  logic [CTL_W-1:0]  ctl2,
  input  logic              dat_inhibit,
  input  logic              stopped,
  input  logic              cmd_wr,
  input  logic              cmd_data_present,
  input  logic [1:0]        cmd_rsp_type,
  input  logic [1:0]        cmd_type,
  input  logic [NORM_W-1:0] norm_sts,
  input  logic [NORM_W-1:0] norm_sig_en,
  input  logic [ERR_W-1:0]  err_sts,
  input  logic [ERR_W-1:0]  err_sig_en,
  input  logic              wake_ins_en,
  input  logic              wake_rem_en,
  output logic              cmd_issue,
  output logic              cmd_reject,
  output logic              irq
);
  localparam logic [1:0] RSP_BUSY   = 2'd3;
  localparam logic [1:0] TYPE_ABORT = 2'd3;

  logic pwr_checked, pwr_ok, uses_dat, dat_blocked, permit;
  logic sig_hit, wake_hit, irq_next;

  assign pwr_checked = ctl2[OPC_POS] | ctl2[IPC_POS];
  assign pwr_ok      = pwr_on | ~pwr_checked;
  assign uses_dat    = cmd_data_present | (cmd_rsp_type == RSP_BUSY);
  assign dat_blocked = uses_dat & (cmd_type != TYPE_ABORT) & (dat_inhibit | stopped);
  assign permit      = clk_on & pwr_ok & ~dat_blocked;

  assign sig_hit  = (|(norm_sts & norm_sig_en)) | (|(err_sts & err_sig_en));
  assign wake_hit = (norm_sts[INS_POS] & wake_ins_en) | (norm_sts[REM_POS] & wake_rem_en);
  assign irq_next = sig_hit | wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_issue  <= 1'b0;
      cmd_reject <= 1'b0;
      irq        <= 1'b0;
    end else begin
      cmd_issue  <= cmd_wr & permit;
      cmd_reject <= cmd_wr & ~permit;
      irq        <= irq_next;
    end
  end
endmodule

// File: rtl/sd_cmd_gate_chk.sv
module sd_cmd_gate_chk #(
  parameter int NORM_W  = 16,
  parameter int ERR_W   = 16,
  parameter int CTL_W   = 32,
  parameter int INS_POS = 6,
  parameter int REM_POS = 7,
  parameter int OPC_POS = 12,
  parameter int IPC_POS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_on,
  input logic              pwr_on,
  input logic [CTL_W-1:0]  ctl2,
  input logic              dat_inhibit,
  input logic              stopped,
  input logic              cmd_wr,
  input logic              cmd_data_present,
  input logic [1:0]        cmd_rsp_type,
  input logic [1:0]        cmd_type,
  input logic [NORM_W-1:0] norm_sts,
  input logic [NORM_W-1:0] norm_sig_en,
  input logic [ERR_W-1:0]  err_sts,
  input logic [ERR_W-1:0]  err_sig_en,
  input logic              wake_ins_en,
  input logic              wake_rem_en,
  input logic              cmd_issue,
  input logic              cmd_reject,
  input logic              irq
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!cmd_issue && !cmd_reject && !irq);
  end

  assert_clk_off_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !clk_on) |=> cmd_reject);

  assert_power_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !pwr_on && (ctl2[OPC_POS] || ctl2[IPC_POS])) |=> cmd_reject);

  assert_busy_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (dat_inhibit || stopped) && cmd_type != 2'd3 &&
     (cmd_data_present || cmd_rsp_type == 2'd3)) |=> cmd_reject);

  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> $countones({cmd_issue, cmd_reject}) == 1);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (!cmd_issue && !cmd_reject));

  assert_sig_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(norm_sts & norm_sig_en)) || (|(err_sts & err_sig_en))) |=> irq);

  assert_wake_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((norm_sts[INS_POS] && wake_ins_en) || (norm_sts[REM_POS] && wake_rem_en)) |=> irq);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(norm_sts & norm_sig_en)) && !(|(err_sts & err_sig_en)) &&
     !(norm_sts[INS_POS] && wake_ins_en) && !(norm_sts[REM_POS] && wake_rem_en)) |=> !irq);
endmodule

bind sd_cmd_gate sd_cmd_gate_chk #(
  .NORM_W(NORM_W), .ERR_W(ERR_W), .CTL_W(CTL_W), .INS_POS(INS_POS),
  .REM_POS(REM_POS), .OPC_POS(OPC_POS), .IPC_POS(IPC_POS)
) u_chk (.*);

// File: tb/sd_cmd_gate_test.sv
`timescale 1ns/1ps
module sd_cmd_gate_test;
  localparam int NW = 16, EW = 10, CW = 32;
  logic clk = 0, rst_n = 0;
  logic clk_on, pwr_on, dat_inhibit, stopped, cmd_wr, cmd_data_present;
  logic [CW-1:0] ctl2;
  logic [1:0] cmd_rsp_type, cmd_type;
  logic [NW-1:0] norm_sts, norm_sig_en;
  logic [EW-1:0] err_sts, err_sig_en;
  logic wake_ins_en, wake_rem_en;
  logic cmd_issue, cmd_reject, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sd_cmd_gate #(.NORM_W(NW), .ERR_W(EW), .CTL_W(CW)) uut (.*);

  function automatic bit exp_permit();
    bit pwr_ok = pwr_on || !(ctl2[12] || ctl2[3]);
    bit dat = cmd_data_present || cmd_rsp_type == 2'd3;
    bit blk = dat && cmd_type != 2'd3 && (dat_inhibit || stopped);
    return clk_on && pwr_ok && !blk;
  endfunction

  function automatic bit exp_irq();
    return (|(norm_sts & norm_sig_en)) || (|(err_sts & err_sig_en)) ||
           (norm_sts[6] && wake_ins_en) || (norm_sts[7] && wake_rem_en);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    bit ei, er, eq;
    ei = cmd_wr && exp_permit();
    er = cmd_wr && !exp_permit();
    eq = exp_irq();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " issue"}, cmd_issue, ei);
    chk({tag, " reject"}, cmd_reject, er);
    chk({tag, " irq"}, irq, eq);
  endtask

  task automatic idle();
    clk_on = 1; pwr_on = 1; ctl2 = '0; dat_inhibit = 0; stopped = 0;
    cmd_wr = 0; cmd_data_present = 0; cmd_rsp_type = 2'd2; cmd_type = 0;
    norm_sts = '0; norm_sig_en = '0; err_sts = '0; err_sig_en = '0;
    wake_ins_en = 0; wake_rem_en = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5d1c;
    void'($urandom(seed));
    idle();
    cmd_wr = 1; norm_sts = '1; norm_sig_en = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset issue", cmd_issue, 0);
    chk("R1 reset reject", cmd_reject, 0);
    chk("R1 reset irq", irq, 0);
    idle();
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset irq", irq, 0);

    idle(); cmd_wr = 1; cyc("R7 plain issue");
    if (cmd_issue !== 1) begin errors++; $display("FAIL R7 actual=%b expected=1", cmd_issue); end
    checks++;
    idle(); cyc("R7 no write");
    idle(); cmd_wr = 1; clk_on = 0; cyc("R2 clock off");
    idle(); cmd_wr = 1; pwr_on = 0; cyc("R3 power ignored");
    idle(); cmd_wr = 1; pwr_on = 0; ctl2[12] = 1; cyc("R3 bit12 power off");
    idle(); cmd_wr = 1; pwr_on = 0; ctl2[3] = 1; cyc("R3 bit3 power off");
    idle(); cmd_wr = 1; ctl2 = '1; cyc("R3 powered");
    idle(); cmd_wr = 1; dat_inhibit = 1; cmd_rsp_type = 2'd3; cyc("R4 busy rsp uses data");
    idle(); cmd_wr = 1; stopped = 1; cmd_data_present = 1; cyc("R5 stopped data cmd");
    idle(); cmd_wr = 1; dat_inhibit = 1; cmd_data_present = 1; cmd_type = 2'd3; cyc("R5 abort passes");
    idle(); cmd_wr = 1; dat_inhibit = 1; stopped = 1; cmd_rsp_type = 2'd1; cyc("R6 no data line");
    idle(); err_sts[9] = 1; err_sig_en[9] = 1; cyc("R8 error bit");
    idle(); norm_sts[0] = 1; norm_sig_en[0] = 1; cyc("R8 normal bit");
    idle(); norm_sts[6] = 1; wake_ins_en = 1; cyc("R9 insert wake");
    idle(); norm_sts[7] = 1; wake_rem_en = 1; cyc("R9 remove wake");
    idle(); norm_sts = '1; err_sts = '1; cyc("R10 no enables");

    for (int i = 0; i < 3000; i++) begin
      clk_on = ($urandom % 8) != 0;
      pwr_on = $urandom;
      ctl2 = ($urandom % 3 == 0) ? $urandom : '0;
      dat_inhibit = ($urandom % 3) == 0;
      stopped = ($urandom % 4) == 0;
      cmd_wr = $urandom;
      cmd_data_present = $urandom;
      cmd_rsp_type = $urandom;
      cmd_type = $urandom;
      norm_sts = $urandom & $urandom & $urandom;
      norm_sig_en = $urandom & $urandom;
      err_sts = $urandom & $urandom & $urandom;
      err_sig_en = $urandom & $urandom;
      wake_ins_en = $urandom;
      wake_rem_en = $urandom;
      cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule